// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Prescaler

This block divides a reference clock by an integer that firmware may change while the system runs. The divided clock feeds a processor. Firmware can slow it down to save power and speed it up again when needed. After hardware reset the divisor is 16. This slow default lets early start-up code fetch from slow memory whatever the reference frequency is. With a 48 MHz reference, the divisors 4 and 6 give 12 MHz and 8 MHz.

A write strobe with a valid divisor stores the value in a shadow register and raises a pending flag. The running divisor is replaced from the shadow only at the end of a complete output period. At that point the internal counter wraps and the output is low, so the output never shows a shortened phase. The pending flag drops on the edge where the new divisor takes effect. Out-of-range values are discarded.

Top module: `pclk_divider`

## Requirements
- R1: After reset is released the divisor is 16, `pclk_out` is low and `div_pending` is 0; the first output periods last 16 reference cycles, 8 high and 8 low.
- R2: For any applied divisor D from 2 to 16, every output period is exactly D reference cycles, with floor(D/2) cycles high followed by D minus floor(D/2) cycles low, so an odd divisor has the high phase one cycle shorter.
- R3: A write of a value from 2 to 16 (`div_wr` high at a rising reference edge) sets `div_pending` to 1 from that edge on.
- R4: An output period already in progress when a valid write arrives completes at the old divisor length; the first full period that starts afterwards uses the new divisor.
- R5: `div_pending` returns to 0 on the same reference edge on which the new divisor is loaded, which is the edge where `pclk_out` rises to begin the first new-length period.
- R6: A write of 0, 1 or any value above 16 is ignored: `div_pending` keeps its value and the output period is unchanged.
- R7: Every output period equals either the old or the new divisor, and the high and low phases are each at least one reference cycle long; the divisor is only replaced while the output is low at the wrap.
- R8: A valid write sampled on the same edge as a counter wrap is stored but not applied at that wrap: `div_pending` stays 1, the period starting at that edge has the previous length, and the new value is applied at the following wrap.
- R9: When several valid writes arrive before a wrap, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock to be divided |
| arst_n | input | 1 | Asynchronous reset, active low |
| div_wr | input | 1 | Write strobe for a new divisor, sampled on the rising edge of ref_clk |
| div_val | input | DIV_W (5) | Requested divisor value |
| pclk_out | output | 1 | Divided processor clock |
| div_pending | output | 1 | High while a written divisor waits to be applied |

## Verification
A divisor write and a counter wrap can land on the same reference edge. In that case the shadow update and the shadow-to-active load compete. The bench provokes this by finding a rising output edge and then counting D minus one reference cycles before strobing the write, so the write is sampled exactly on the wrap edge. It judges the result by three things. `div_pending` must still be high after that edge. The period that begins there must keep the previous length. The period after it must take the new length as the flag drops.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

   // True when a requested divisor lies in the legal range [2, max]
   function automatic logic div_ok(input int unsigned v, input int unsigned max_div);
      return (v >= 2) && (v <= max_div);
   endfunction

endpackage

// File: rtl/pclk_div_shadow.sv
module pclk_div_shadow #(
   parameter int unsigned DIV_W     = 5,
   parameter int unsigned DIV_MAX   = 16,
   parameter int unsigned DIV_RESET = 16
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             wr,
   input  logic [DIV_W-1:0] wr_val,
   input  logic             wrap,
   output logic [DIV_W-1:0] shadow_q,
   output logic             pend_q
);
   import pclk_div_pkg::*;

   logic wr_ok;
   assign wr_ok = wr && div_ok(32'(wr_val), DIV_MAX);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         shadow_q <= DIV_W'(DIV_RESET);
         pend_q   <= 1'b0;
      end else if (wr_ok) begin
         shadow_q <= wr_val;
         pend_q   <= 1'b1;
      end else if (wrap) begin
         pend_q   <= 1'b0;
      end
   end

   // R3
   pend_set_chk: assert property (@(posedge clk) disable iff (!arst_n)
      wr_ok |=> (pend_q && shadow_q == $past(wr_val)));
   // R5
   pend_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (wrap && !wr_ok) |=> !pend_q);
   // R6
   bad_write_ignored_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (wr && !wr_ok) |=> $stable(shadow_q));

endmodule

// File: rtl/pclk_div_core.sv
module pclk_div_core #(
   parameter int unsigned DIV_W      = 5,
   parameter int unsigned DIV_MAX    = 16,
   parameter int unsigned DIV_RESET  = 16,
   parameter bit          HIGH_SHORT = 1'b1
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [DIV_W-1:0] load_val,
   output logic             wrap,
   output logic             pclk_o
);
   logic [DIV_W-1:0] cur_q, cnt_q, cur_nxt, cnt_nxt, hi_nxt;

   assign wrap    = (cnt_q == cur_q - 1'b1);
   assign cur_nxt = wrap ? load_val : cur_q;
   assign cnt_nxt = wrap ? '0 : cnt_q + 1'b1;

   // Length of the high phase for the next period
   generate
      if (HIGH_SHORT) begin : g_hi_floor
         assign hi_nxt = cur_nxt >> 1;
      end else begin : g_hi_ceil
         logic [DIV_W:0] inc;
         assign inc    = {1'b0, cur_nxt} + 1'b1;
         assign hi_nxt = inc[DIV_W:1];
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cur_q  <= DIV_W'(DIV_RESET);
         cnt_q  <= DIV_W'(DIV_RESET - 1);
         pclk_o <= 1'b0;
      end else begin
         cur_q  <= cur_nxt;
         cnt_q  <= cnt_nxt;
         pclk_o <= (cnt_nxt < hi_nxt);
      end
   end

   // R7
   load_when_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
      wrap |-> !pclk_o);
   // R4
   hold_mid_period_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !wrap |=> $stable(cur_q));
   // R2
   div_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (cur_q >= 2) && (cur_q <= DIV_W'(DIV_MAX)));

endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
   parameter int unsigned DIV_W      = 5,
   parameter int unsigned DIV_MAX    = 16,
   parameter int unsigned DIV_RESET  = 16,
   parameter bit          HIGH_SHORT = 1'b1
) (
   input  logic             ref_clk,
   input  logic             arst_n,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_val,
   output logic             pclk_out,
   output logic             div_pending
);
   localparam int unsigned DIV_LIMIT = (1 << DIV_W) - 1;

   generate
      if (DIV_MAX < 2 || DIV_MAX > DIV_LIMIT) begin : g_bad_max
         $error("pclk_divider: DIV_MAX does not fit DIV_W");
      end
      if (DIV_RESET < 2 || DIV_RESET > DIV_MAX) begin : g_bad_rst
         $error("pclk_divider: DIV_RESET outside [2, DIV_MAX]");
      end
   endgenerate

   logic [DIV_W-1:0] shadow;
   logic             wrap;

   pclk_div_shadow #(
      .DIV_W(DIV_W), .DIV_MAX(DIV_MAX), .DIV_RESET(DIV_RESET)
   ) u_shadow (
      .clk(ref_clk), .arst_n(arst_n), .wr(div_wr), .wr_val(div_val),
      .wrap(wrap), .shadow_q(shadow), .pend_q(div_pending)
   );

   pclk_div_core #(
      .DIV_W(DIV_W), .DIV_MAX(DIV_MAX), .DIV_RESET(DIV_RESET),
      .HIGH_SHORT(HIGH_SHORT)
   ) u_core (
      .clk(ref_clk), .arst_n(arst_n), .load_val(shadow),
      .wrap(wrap), .pclk_o(pclk_out)
   );

endmodule

// File: tb/pclk_divider_test.sv
`timescale 1ns/1ps
module pclk_divider_test;
   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic       div_wr = 1'b0;
   logic [4:0] div_val = '0;
   logic       pclk_out, div_pending;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pclk_divider uut (
      .ref_clk(clk), .arst_n(arst_n), .div_wr(div_wr), .div_val(div_val),
      .pclk_out(pclk_out), .div_pending(div_pending)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Phase-shape monitor (R7): every full period has floor(D/2) high and D-floor(D/2) low
   int  m_hi = 0, m_lo = 0;
   bit  m_prev = 1'b0, m_armed = 1'b0;
   always @(negedge clk) begin
      if (!arst_n) begin
         m_armed = 1'b0; m_prev = 1'b0; m_hi = 0; m_lo = 0;
      end else begin
         if (pclk_out && !m_prev) begin
            if (m_armed) begin
               check((m_hi + m_lo) >= 2 && (m_hi + m_lo) <= 16, "R7 period", m_hi + m_lo, 2);
               check(m_hi == (m_hi + m_lo) / 2, "R7 high phase", m_hi, (m_hi + m_lo) / 2);
            end
            m_armed = 1'b1; m_hi = 0; m_lo = 0;
         end
         if (pclk_out) m_hi++; else m_lo++;
         m_prev = pclk_out;
      end
   end

   // From a rising point, count negedges until the next rise (starting at n0)
   task automatic wait_rise(input int n0, output int n);
      bit prev;
      n = n0;
      forever begin
         prev = pclk_out;
         @(negedge clk);
         n++;
         if (!prev && pclk_out) break;
      end
   endtask

   // Measure the period beginning at the current (high) sample; ends at the next rise
   task automatic measure_cur(output int hi, output int lo);
      hi = 0; lo = 0;
      while (pclk_out)  begin hi++; @(negedge clk); end
      while (!pclk_out) begin lo++; @(negedge clk); end
   endtask

   task automatic strobe(input int v);
      div_val = 5'(v);
      div_wr  = 1'b1;
      @(negedge clk);
      div_wr  = 1'b0;
   endtask

   task automatic check_shape(input int d, input string req);
      int hi, lo;
      measure_cur(hi, lo);
      check(hi + lo == d, {req, " period"}, hi + lo, d);
      check(hi == d / 2, {req, " high"}, hi, d / 2);
   endtask

   task automatic t_reset();
      int n;
      @(negedge clk);
      check(pclk_out == 1'b0, "R1 out in reset", pclk_out, 0);
      check(div_pending == 1'b0, "R1 pending in reset", div_pending, 0);
      arst_n = 1'b1;
      @(negedge clk);
      wait_rise(0, n);
      check_shape(16, "R1");
      check_shape(16, "R1");
   endtask

   // Called at a rising point with current divisor old_d (>=3)
   task automatic t_change(input int old_d, input int new_d);
      int n;
      @(negedge clk);
      strobe(new_d);
      check(div_pending == 1'b1, "R3 pending set", div_pending, 1);
      wait_rise(2, n);
      check(n == old_d, "R4 old period completes", n, old_d);
      check(div_pending == 1'b0, "R5 pending cleared at load", div_pending, 0);
      check_shape(new_d, "R2");
      check_shape(new_d, "R2");
   endtask

   // Write sampled on the wrap edge
   task automatic t_collide(input int old_d, input int new_d);
      repeat (old_d - 1) @(negedge clk);
      strobe(new_d);
      check(div_pending == 1'b1, "R8 pending kept at wrap", div_pending, 1);
      check(pclk_out == 1'b1, "R8 new period started", pclk_out, 1);
      check_shape(old_d, "R8 previous length");
      check(div_pending == 1'b0, "R8 pending cleared later", div_pending, 0);
      check_shape(new_d, "R8 new length");
   endtask

   task automatic t_ignore(input int d);
      int n;
      @(negedge clk);
      strobe(0);
      check(div_pending == 1'b0, "R6 zero ignored", div_pending, 0);
      strobe(1);
      check(div_pending == 1'b0, "R6 one ignored", div_pending, 0);
      strobe(17);
      strobe(31);
      check(div_pending == 1'b0, "R6 over-range ignored", div_pending, 0);
      wait_rise(5, n);
      check(n == d, "R6 period kept", n, d);
      check_shape(d, "R6");
   endtask

   task automatic t_last_wins(input int d, input int a, input int b);
      int n;
      @(negedge clk);
      strobe(a);
      strobe(b);
      check(div_pending == 1'b1, "R9 pending", div_pending, 1);
      wait_rise(3, n);
      check(n == d, "R9 old period", n, d);
      check_shape(b, "R9 last value");
   endtask

   initial begin
      t_reset();
      t_change(16, 4);
      t_change(4, 6);
      t_change(6, 5);
      t_change(5, 3);
      t_change(3, 2);
      t_collide(2, 9);
      t_ignore(9);
      t_last_wins(9, 12, 7);
      t_change(7, 16);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule